// File: doc/BRIEF.md
# Grouped Polled Interrupt Controller

This block gathers interrupt events for a small 8-bit processor and turns them into two level lines: a maskable `irq_o` and a non-maskable `nmi_o`. Events arrive either as one-cycle strobes from on-chip peripherals or as level changes on three external pins. The polarity of each pin can be chosen. Every event sets a sticky request bit inside a group. There are three IRQ groups of eight bits each, plus a two-bit NMI group that holds the external-pin source and a mute source.

A request bit latches whether or not it is enabled. The enables only gate the processor lines. Each group also has a summary bit, which stays set while any of its members is pending. There is no hardware priority. The service routine reads the summary register, then the group register, in whatever order it wants, and clears the bits it has handled by writing ones to them. All registers sit on a byte-wide bus. Reads are combinational and have no side effects. Writes take effect on the clock edge.

Edge pin 0 feeds NMI bit 0. Edge pin 1 feeds IRQ group 2 bit 1. Edge pin 2 (the vertical-sync pulse) feeds IRQ group 2 bit 0. Trigger-select bit k sets the polarity of edge pin k.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, all enable registers read 0x00, all request registers and the summary register read 0x00, the trigger-select register (offset 0x1F) reads 0xFF, and `irq_o` and `nmi_o` are low.
- R2: A strobe or selected pin edge sets its request bit even when its enable bit is 0, and `irq_o` then stays low.
- R3: The enable registers read back the last value written: NMI enable at 0x17 (bit 0 external pin, bit 1 mute), IRQ group g enable at 0x18+g.
- R4: Summary register 0x1B holds bit g (g = 0..2) set while any request of IRQ group g is set, and bit 3 set while any NMI request is set. A bit clears only once every member of its group is clear.
- R5: Writing the NMI poll register (0x16) or an IRQ request register (0x1C+g) clears the bits written as 1 and leaves the bits written as 0 unchanged. With no such write, a set request stays set.
- R6: `irq_o` equals, one clock after, the OR over all groups of request AND enable, and stays high until the pending enabled request is cleared.
- R7: `nmi_o` equals, one clock after, the OR of the NMI requests AND the NMI enables.
- R8: Each edge pin passes through a two-flop synchronizer and triggers on a rising edge when its trigger-select bit is 1, or on a falling edge when that bit is 0. The opposite edge sets nothing. The trigger-select register changes only on a write to it.
- R9: When a set event and a write-one-to-clear hit the same request bit in the same cycle, the bit ends up set.
- R10: Reads of unmapped offsets return 0x00. A write to the summary register changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| edge_pin_i | input | 3 | Asynchronous edge-triggered pins |
| irq_evt_i | input | 24 | Peripheral event strobes, group g at bits 8g+7..8g |
| mute_evt_i | input | 1 | Mute event strobe for NMI bit 1 |
| bus_addr_i | input | 5 | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| irq_o | output | 1 | Maskable interrupt line, registered |
| nmi_o | output | 1 | Non-maskable interrupt line, registered |

## Verification
Strobes are fired with their enables off and then on. This separates request latching from line gating. Two requests in one group are cleared one at a time, which shows that the summary bit waits for the last member to clear. Pins are driven in both directions under both polarity settings, so that the accepted edge can be told apart from the ignored one. A strobe that coincides with a clear of the same bit shows which of the two wins.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int GROUPS  = 3;
    localparam int GRP_W   = 8;
    localparam int NMI_W   = 2;
    localparam int N_EDGE  = 3;

    localparam logic [ADDR_W-1:0] OFF_NMI_POLL = 5'h16;
    localparam logic [ADDR_W-1:0] OFF_NMI_EN   = 5'h17;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN0  = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_SUMMARY  = 5'h1B;
    localparam logic [ADDR_W-1:0] OFF_IRQ_REQ0 = 5'h1C;
    localparam logic [ADDR_W-1:0] OFF_TRIG     = 5'h1F;

    // edge pin routing
    localparam int EDGE_NMI   = 0;
    localparam int EDGE_LINE  = 1;
    localparam int EDGE_VSYNC = 2;
    localparam int EDGE_GRP   = 2;
    localparam int VSYNC_BIT  = 0;
    localparam int LINE_BIT   = 1;
endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic pulse_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        if (rise_sel_i) pulse_o = sync_q & ~prev_q;
        else            pulse_o = ~sync_q & prev_q;
    end
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] req_o
);
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_we_i ? clr_mask_i : '0;

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_o <= '0;
        else         req_o <= (req_o & ~clr_eff) | set_i;
    end
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [NMI_W-1:0]        nmi_en_o,
    output logic [GROUPS*GRP_W-1:0] irq_en_o,
    output logic [DATA_W-1:0]       trig_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nmi_en_o <= '0;
            trig_o   <= '1;
        end else if (wr_i) begin
            if (addr_i == OFF_NMI_EN) nmi_en_o <= wdata_i[NMI_W-1:0];
            if (addr_i == OFF_TRIG)   trig_o   <= wdata_i;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_en
        localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(int'(OFF_IRQ_EN0) + g);
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                irq_en_o[g*GRP_W +: GRP_W] <= '0;
            else if (wr_i && addr_i == MY_OFF)
                irq_en_o[g*GRP_W +: GRP_W] <= wdata_i[GRP_W-1:0];
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_EDGE-1:0]       edge_pin_i,
    input  logic [GROUPS*GRP_W-1:0] irq_evt_i,
    input  logic                    mute_evt_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic                    bus_wr_i,
    input  logic [DATA_W-1:0]       bus_wdata_i,
    output logic [DATA_W-1:0]       bus_rdata_o,
    output logic                    irq_o,
    output logic                    nmi_o
);
    logic [N_EDGE-1:0]       edge_pulse;
    logic [GROUPS*GRP_W-1:0] irq_set_flat;
    logic [GROUPS*GRP_W-1:0] irq_req_flat;
    logic [GROUPS*GRP_W-1:0] irq_en_flat;
    logic [NMI_W-1:0]        nmi_set;
    logic [NMI_W-1:0]        nmi_req;
    logic [NMI_W-1:0]        nmi_en;
    logic [DATA_W-1:0]       trig_q;
    logic [GROUPS:0]         summary;

    pic_cfg_regs u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .nmi_en_o (nmi_en),
        .irq_en_o (irq_en_flat),
        .trig_o   (trig_q)
    );

    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        pic_edge_det u_det (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pin_i      (edge_pin_i[e]),
            .rise_sel_i (trig_q[e]),
            .pulse_o    (edge_pulse[e])
        );
    end

    always_comb begin
        irq_set_flat = irq_evt_i;
        irq_set_flat[EDGE_GRP*GRP_W + VSYNC_BIT] =
            irq_evt_i[EDGE_GRP*GRP_W + VSYNC_BIT] | edge_pulse[EDGE_VSYNC];
        irq_set_flat[EDGE_GRP*GRP_W + LINE_BIT] =
            irq_evt_i[EDGE_GRP*GRP_W + LINE_BIT] | edge_pulse[EDGE_LINE];
        nmi_set = {mute_evt_i, edge_pulse[EDGE_NMI]};
    end

    pic_req_bank #(.W(NMI_W)) u_nmi_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (nmi_set),
        .clr_we_i   (bus_wr_i && bus_addr_i == OFF_NMI_POLL),
        .clr_mask_i (bus_wdata_i[NMI_W-1:0]),
        .req_o      (nmi_req)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] REQ_OFF = ADDR_W'(int'(OFF_IRQ_REQ0) + g);
        pic_req_bank #(.W(GRP_W)) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .set_i      (irq_set_flat[g*GRP_W +: GRP_W]),
            .clr_we_i   (bus_wr_i && bus_addr_i == REQ_OFF),
            .clr_mask_i (bus_wdata_i[GRP_W-1:0]),
            .req_o      (irq_req_flat[g*GRP_W +: GRP_W])
        );
        assign summary[g] = |irq_req_flat[g*GRP_W +: GRP_W];
    end
    assign summary[GROUPS] = |nmi_req;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_o <= 1'b0;
            nmi_o <= 1'b0;
        end else begin
            irq_o <= |(irq_req_flat & irq_en_flat);
            nmi_o <= |(nmi_req & nmi_en);
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == OFF_NMI_POLL) bus_rdata_o = DATA_W'(nmi_req);
        if (bus_addr_i == OFF_NMI_EN)   bus_rdata_o = DATA_W'(nmi_en);
        if (bus_addr_i == OFF_SUMMARY)  bus_rdata_o = DATA_W'(summary);
        if (bus_addr_i == OFF_TRIG)     bus_rdata_o = trig_q;
        for (int g = 0; g < GROUPS; g++) begin
            if (bus_addr_i == ADDR_W'(int'(OFF_IRQ_EN0) + g))
                bus_rdata_o = DATA_W'(irq_en_flat[g*GRP_W +: GRP_W]);
            if (bus_addr_i == ADDR_W'(int'(OFF_IRQ_REQ0) + g))
                bus_rdata_o = DATA_W'(irq_req_flat[g*GRP_W +: GRP_W]);
        end
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
    import pic_pkg::*;
(
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    irq_o,
    input logic                    nmi_o,
    input logic [GROUPS*GRP_W-1:0] irq_req_flat,
    input logic [GROUPS*GRP_W-1:0] irq_en_flat,
    input logic [GROUPS*GRP_W-1:0] irq_set_flat,
    input logic [NMI_W-1:0]        nmi_req,
    input logic [NMI_W-1:0]        nmi_en,
    input logic [DATA_W-1:0]       trig_q,
    input logic                    bus_wr_i,
    input logic [ADDR_W-1:0]       bus_addr_i
);
    // R6
    irq_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|(irq_req_flat & irq_en_flat))));

    // R7
    nmi_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (nmi_o == $past(|(nmi_req & nmi_en))));

    // R2
    masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_en_flat == '0) |=> !irq_o);

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_set_flat) |=> ((irq_req_flat & $past(irq_set_flat)) == $past(irq_set_flat)));

    // R5
    sticky_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_wr_i |=> ((irq_req_flat & $past(irq_req_flat)) == $past(irq_req_flat)));

    // R8
    trig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_wr_i && bus_addr_i == OFF_TRIG) |=> $stable(trig_q));
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_o        (irq_o),
    .nmi_o        (nmi_o),
    .irq_req_flat (irq_req_flat),
    .irq_en_flat  (irq_en_flat),
    .irq_set_flat (irq_set_flat),
    .nmi_req      (nmi_req),
    .nmi_en       (nmi_en),
    .trig_q       (trig_q),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i)
);

// File: tb/pic_ctrl_test.sv
`timescale 1ns/1ps
module pic_ctrl_test;
    import pic_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N_EDGE-1:0]       pins = '0;
    logic [GROUPS*GRP_W-1:0] evt = '0;
    logic                    mute = 1'b0;
    logic [ADDR_W-1:0]       addr = '0;
    logic                    wr = 1'b0;
    logic [DATA_W-1:0]       wdata = '0;
    logic [DATA_W-1:0]       rdata;
    logic                    irq, nmi;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pic_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .edge_pin_i(pins), .irq_evt_i(evt),
        .mute_evt_i(mute), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .nmi_o(nmi)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick(1);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic strobe(input int bitpos);
        evt[bitpos] = 1'b1;
        tick(1);
        evt[bitpos] = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 5'h16; a <= 5'h1E; a++) begin
            rd_reg(5'(a), d);
            check("R1", $sformatf("reg %h after reset", a), d, 8'h00);
        end
        rd_reg(OFF_TRIG, d);
        check("R1", "trigger reset", d, 8'hFF);
        check("R1", "irq reset", {7'b0, irq}, 8'h00);
        check("R1", "nmi reset", {7'b0, nmi}, 8'h00);
    endtask

    task automatic t_masked_latch();
        logic [7:0] d;
        strobe(3);
        rd_reg(5'h1C, d);
        check("R2", "latched while disabled", d, 8'h08);
        tick(2);
        check("R2", "irq low while disabled", {7'b0, irq}, 8'h00);
        rd_reg(OFF_SUMMARY, d);
        check("R4", "summary group0", d, 8'h01);
    endtask

    task automatic t_enable_and_clear();
        logic [7:0] d;
        wr_reg(5'h18, 8'hA5);
        rd_reg(5'h18, d);
        check("R3", "enable g0 readback", d, 8'hA5);
        wr_reg(5'h19, 8'h3C);
        rd_reg(5'h19, d);
        check("R3", "enable g1 readback", d, 8'h3C);
        wr_reg(5'h18, 8'h08);
        tick(1);
        check("R6", "irq after enable", {7'b0, irq}, 8'h01);
        wr_reg(5'h1C, 8'h00);
        rd_reg(5'h1C, d);
        check("R5", "zero write keeps request", d, 8'h08);
        tick(2);
        check("R6", "irq held while pending", {7'b0, irq}, 8'h01);
        wr_reg(5'h1C, 8'h08);
        rd_reg(5'h1C, d);
        check("R5", "one write clears", d, 8'h00);
        tick(1);
        check("R6", "irq drops after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_summary();
        logic [7:0] d;
        strobe(GRP_W + 0);
        strobe(GRP_W + 5);
        rd_reg(OFF_SUMMARY, d);
        check("R4", "summary g1 set", d, 8'h02);
        wr_reg(5'h1D, 8'h01);
        rd_reg(OFF_SUMMARY, d);
        check("R4", "summary g1 held with one member", d, 8'h02);
        wr_reg(5'h1D, 8'h20);
        rd_reg(OFF_SUMMARY, d);
        check("R4", "summary g1 cleared", d, 8'h00);
    endtask

    task automatic t_nmi();
        logic [7:0] d;
        wr_reg(OFF_NMI_EN, 8'h02);
        rd_reg(OFF_NMI_EN, d);
        check("R3", "nmi enable readback", d, 8'h02);
        mute = 1'b1; tick(1); mute = 1'b0;
        tick(1);
        check("R7", "nmi asserted", {7'b0, nmi}, 8'h01);
        rd_reg(OFF_NMI_POLL, d);
        check("R7", "nmi poll", d, 8'h02);
        rd_reg(OFF_SUMMARY, d);
        check("R4", "summary nmi bit", d, 8'h08);
        wr_reg(OFF_NMI_POLL, 8'h02);
        tick(1);
        check("R7", "nmi released", {7'b0, nmi}, 8'h00);
        wr_reg(OFF_NMI_EN, 8'h00);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        pins[EDGE_NMI] = 1'b1; tick(4);
        rd_reg(OFF_NMI_POLL, d);
        check("R8", "rising edge pin0", d, 8'h01);
        wr_reg(OFF_NMI_POLL, 8'h01);
        wr_reg(OFF_TRIG, 8'hFE);
        rd_reg(OFF_TRIG, d);
        check("R8", "trigger write", d, 8'hFE);
        pins[EDGE_NMI] = 1'b0; tick(4);
        rd_reg(OFF_NMI_POLL, d);
        check("R8", "falling edge pin0", d, 8'h01);
        wr_reg(OFF_NMI_POLL, 8'h01);
        pins[EDGE_VSYNC] = 1'b1; tick(4);
        rd_reg(5'h1E, d);
        check("R8", "vsync rising", d, 8'h01);
        wr_reg(5'h1E, 8'h01);
        pins[EDGE_VSYNC] = 1'b0; tick(4);
        rd_reg(5'h1E, d);
        check("R8", "vsync falling ignored", d, 8'h00);
        pins[EDGE_LINE] = 1'b1; tick(4);
        rd_reg(5'h1E, d);
        check("R8", "line pin rising", d, 8'h02);
        wr_reg(5'h1E, 8'h02);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        strobe(2*GRP_W + 4);
        evt[2*GRP_W + 4] = 1'b1;
        wr_reg(5'h1E, 8'h10);
        evt[2*GRP_W + 4] = 1'b0;
        rd_reg(5'h1E, d);
        check("R9", "set beats clear", d, 8'h10);
        wr_reg(5'h1E, 8'h10);
        rd_reg(5'h1E, d);
        check("R9", "later clear works", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        rd_reg(5'h00, d);
        check("R10", "unmapped read", d, 8'h00);
        strobe(1);
        wr_reg(OFF_SUMMARY, 8'hFF);
        rd_reg(OFF_SUMMARY, d);
        check("R10", "summary write ignored", d, 8'h01);
        rd_reg(5'h1C, d);
        check("R10", "summary write leaves requests", d, 8'h02);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_masked_latch();
        t_enable_and_clear();
        t_summary();
        t_nmi();
        t_edges();
        t_set_wins();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule